// File: doc/BRIEF.md
# Bridge Event and Legacy Interrupt Status Unit

This unit sits beside a bus bridge and turns two kinds of input into interrupt requests. Single-cycle event pulses from the bridge and link logic are latched into a sparse miscellaneous status word. Four level-sensitive legacy interrupt inputs (INTA to INTD) are reflected into a small legacy status word. Each status word has an enable word beside it. A set enable bit lets its status bit raise the matching output line, and a clear enable bit keeps it quiet. A message-class filter decides which event classes may post status at all. A single global enable bit gates both output lines.

Software reaches the six registers through a plain 32-bit word port. A write is a single-cycle strobe with an address and data. Read data is combinational from the current address, so it needs no strobe. Status bits are write-one-to-clear. There is no streaming data path, so the port has no valid/ready handshake and never applies back-pressure. Decoding of incoming link messages is done upstream; it reaches this unit as one pulse per status position.

Top module: `pcie_evt_irq_unit`

## Requirements
- R1: After reset every register reads 0 and both `misc_irq` and `intx_irq` are low.
- R2: The miscellaneous status word (word address 0x00) implements only bits 0,1,4,5,6,7,16,17,18,20,22,23,24,25,26 (mask 0x07D700F3). A permitted pulse on `evt_misc[i]` sets status bit i at the next clock edge. All other positions always read 0.
- R3: Writing 1 to a status bit clears it at the clock edge of the write. Writing 0 leaves the bit unchanged.
- R4: When a permitted event pulse and a clearing write hit the same miscellaneous bit in the same cycle, the bit is set after that edge.
- R5: The legacy status word (0x08) holds INTA..INTD in bits 0..3. While interrupt-class forwarding is on, a bit is set every cycle its `intx_lvl` input is high, even across a clearing write. After the input drops, the bit stays set until it is cleared.
- R6: The filter register (0x10) has three enables: bit 1 for power/link class (status bits 24..26), bit 2 for interrupt class (legacy inputs) and bit 3 for error class (status bits 16,17,18,20,22,23). Status bits 0..7 take no filter. The filter's other bits read 0.
- R7: Enable registers are at 0x04 (miscellaneous, implemented bits only) and 0x0C (legacy, bits 3..0). A 1 enables the interrupt and a 0 disables it.
- R8: Bit 0 of the global register (0x14) gates both outputs. While it is 0 both outputs are low.
- R9: Each output is high exactly when the global enable is 1 and its status AND its enable is nonzero. The output changes right after the clock edge that changed the state.
- R10: Unmapped word addresses read 0 and ignore writes. Unimplemented bit positions read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_misc | input | 32 | Event pulses, one per miscellaneous status position |
| intx_lvl | input | 4 | Legacy interrupt levels INTA..INTD |
| misc_irq | output | 1 | Miscellaneous interrupt request |
| intx_irq | output | 1 | Legacy interrupt request |

## Verification
The bench targets a same-cycle event and clear on one bit. A design that gave the clear priority would lose that event and read 0. It holds a legacy level high while writing ones to its status bit; a design that let the write win would drop an interrupt still asserted on the wire. It posts events with each filter class switched off, which shows up a design that latches filtered classes, and it writes all-ones to check that holes in the sparse layout and unmapped words stay at 0. It also compares both output lines against a bench model every cycle under random traffic, so a global gate or mask with the wrong polarity shows up at once.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DATA_W = 32;
  localparam int INTX_N = 4;
  localparam int NREG   = 6;

  // word indices of the register map
  localparam int IDX_MSTAT = 0;
  localparam int IDX_MEN   = 1;
  localparam int IDX_XSTAT = 2;
  localparam int IDX_XEN   = 3;
  localparam int IDX_FILT  = 4;
  localparam int IDX_GLB   = 5;

  // filter bit positions
  localparam int FILT_PM  = 1;
  localparam int FILT_INT = 2;
  localparam int FILT_ERR = 3;
  localparam logic [3:0] FILT_IMPL = 4'b1110;

  // sparse miscellaneous layout and its classes
  localparam logic [DATA_W-1:0] CLS_BRIDGE = 32'h0000_00F3;
  localparam logic [DATA_W-1:0] CLS_ERR    = 32'h00D7_0000;
  localparam logic [DATA_W-1:0] CLS_PM     = 32'h0700_0000;
  localparam logic [DATA_W-1:0] MISC_IMPL  = CLS_BRIDGE | CLS_ERR | CLS_PM;
  localparam logic [INTX_N-1:0] INTX_IMPL  = '1;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_i[i] | (q & ~clr_i[i]);
      end
      assign stat_o[i] = q;
    end else begin : g_hole
      assign stat_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/evt_class_gate.sv
module evt_class_gate
  import evt_irq_pkg::*;
(
  input  logic [DATA_W-1:0] evt_misc,
  input  logic [INTX_N-1:0] intx_lvl,
  input  logic [3:0]        filt,
  output logic [DATA_W-1:0] misc_set,
  output logic [INTX_N-1:0] intx_set
);
  logic [DATA_W-1:0] allow;
  logic unused_filt;

  assign unused_filt = filt[0];

  always_comb begin
    allow = CLS_BRIDGE;
    if (filt[FILT_ERR]) allow = allow | CLS_ERR;
    if (filt[FILT_PM])  allow = allow | CLS_PM;
  end

  assign misc_set = evt_misc & allow & MISC_IMPL;
  assign intx_set = intx_lvl & {INTX_N{filt[FILT_INT]}};
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
  parameter int W = 32
) (
  input  logic [W-1:0] stat,
  input  logic [W-1:0] en,
  input  logic         glb,
  output logic         irq
);
  assign irq = glb & (|(stat & en));
endmodule

// File: rtl/evt_reg_if.sv
module evt_reg_if
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] misc_stat,
  input  logic [INTX_N-1:0] intx_stat,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wr_mstat,
  output logic              wr_xstat,
  output logic [DATA_W-1:0] misc_en,
  output logic [INTX_N-1:0] intx_en,
  output logic [3:0]        filt,
  output logic              glb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [NREG-1:0]  sel;
  logic [NREG-1:0]  we;
  logic [DATA_W-1:0] word [NREG];
  logic unused_lsb;

  assign idx        = reg_addr[ADDR_W-1:2];
  assign unused_lsb = ^reg_addr[1:0];

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign sel[k] = (idx == IDX_W'(k));
    assign we[k]  = reg_wr & sel[k];
  end

  assign wr_mstat = we[IDX_MSTAT];
  assign wr_xstat = we[IDX_XSTAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_en <= '0;
      intx_en <= '0;
      filt    <= '0;
      glb     <= 1'b0;
    end else begin
      if (we[IDX_MEN])  misc_en <= reg_wdata & MISC_IMPL;
      if (we[IDX_XEN])  intx_en <= reg_wdata[INTX_N-1:0] & INTX_IMPL;
      if (we[IDX_FILT]) filt    <= reg_wdata[3:0] & FILT_IMPL;
      if (we[IDX_GLB])  glb     <= reg_wdata[0];
    end
  end

  assign word[IDX_MSTAT] = misc_stat;
  assign word[IDX_MEN]   = misc_en;
  assign word[IDX_XSTAT] = DATA_W'(intx_stat);
  assign word[IDX_XEN]   = DATA_W'(intx_en);
  assign word[IDX_FILT]  = DATA_W'(filt);
  assign word[IDX_GLB]   = DATA_W'(glb);

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NREG; k++) begin
      if (sel[k]) reg_rdata = reg_rdata | word[k];
    end
  end
endmodule

// File: rtl/pcie_evt_irq_unit.sv
module pcie_evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       evt_misc,
  input  logic [3:0]        intx_lvl,
  output logic              misc_irq,
  output logic              intx_irq
);
  logic [DATA_W-1:0] misc_stat, misc_en, misc_set, misc_clr;
  logic [INTX_N-1:0] intx_stat, intx_en, intx_set, intx_clr;
  logic [3:0]        filt;
  logic              glb, wr_mstat, wr_xstat;

  evt_reg_if #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .misc_stat(misc_stat), .intx_stat(intx_stat),
    .reg_rdata(reg_rdata), .wr_mstat(wr_mstat), .wr_xstat(wr_xstat),
    .misc_en(misc_en), .intx_en(intx_en), .filt(filt), .glb(glb)
  );

  evt_class_gate u_gate (
    .evt_misc(evt_misc), .intx_lvl(intx_lvl), .filt(filt),
    .misc_set(misc_set), .intx_set(intx_set)
  );

  assign misc_clr = wr_mstat ? reg_wdata : '0;
  assign intx_clr = wr_xstat ? reg_wdata[INTX_N-1:0] : '0;

  evt_status_bank #(.W(DATA_W), .IMPL(MISC_IMPL)) u_misc (
    .clk(clk), .rst_n(rst_n), .set_i(misc_set), .clr_i(misc_clr), .stat_o(misc_stat)
  );

  evt_status_bank #(.W(INTX_N), .IMPL(INTX_IMPL)) u_intx (
    .clk(clk), .rst_n(rst_n), .set_i(intx_set), .clr_i(intx_clr), .stat_o(intx_stat)
  );

  evt_irq_out #(.W(DATA_W)) u_misc_irq (
    .stat(misc_stat), .en(misc_en), .glb(glb), .irq(misc_irq)
  );

  evt_irq_out #(.W(INTX_N)) u_intx_irq (
    .stat(intx_stat), .en(intx_en), .glb(glb), .irq(intx_irq)
  );
endmodule

// File: rtl/pcie_evt_irq_unit_chk.sv
module pcie_evt_irq_unit_chk
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [31:0]       evt_misc,
  input logic [3:0]        intx_lvl,
  input logic              misc_irq,
  input logic              intx_irq,
  input logic [31:0]       misc_stat,
  input logic [31:0]       misc_en,
  input logic [3:0]        intx_stat,
  input logic [3:0]        intx_en,
  input logic [3:0]        filt,
  input logic              glb
);
  logic wr_ms;
  assign wr_ms = reg_wr && (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_MSTAT));

  // R3: a cleared bit with no event in that cycle reads 0 afterwards
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ms) |-> ((misc_stat & $past(reg_wdata) & ~$past(evt_misc)) == 32'h0));

  // R4 / R2: unfiltered events always land, clear or not
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((misc_stat & $past(evt_misc & CLS_BRIDGE)) == $past(evt_misc & CLS_BRIDGE)));

  // R6: error class cannot rise while its forwarding enable is off
  assert_filter_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(filt[FILT_ERR]) |-> ((misc_stat & ~$past(misc_stat) & CLS_ERR) == 32'h0));

  // R5: an asserted, forwarded level keeps its status bit set
  assert_intx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(filt[FILT_INT]) |-> ((intx_stat & $past(intx_lvl)) == $past(intx_lvl)));

  // R8: global enable off silences both lines
  assert_glb_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !glb |-> (!misc_irq && !intx_irq));

  // R9: no enabled pending status means no request
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((misc_stat & misc_en) == 32'h0) |-> !misc_irq);

  // R10: unmapped words read zero
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:2] >= (ADDR_W-2)'(NREG)) |-> (reg_rdata == 32'h0));
endmodule

bind pcie_evt_irq_unit pcie_evt_irq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pcie_evt_irq_unit_bench.sv
module pcie_evt_irq_unit_bench;
  localparam logic [31:0] B_IMPL = 32'h07D7_00F3;
  localparam logic [31:0] B_ERR  = 32'h00D7_0000;
  localparam logic [31:0] B_PM   = 32'h0700_0000;
  localparam logic [31:0] B_BR   = 32'h0000_00F3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, reg_wr, misc_irq, intx_irq;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, evt_misc;
  logic [3:0]  intx_lvl;

  pcie_evt_irq_unit u_pcie_evt_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_misc(evt_misc),
    .intx_lvl(intx_lvl), .misc_irq(misc_irq), .intx_irq(intx_irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_ms, m_me;
  logic [3:0]  m_xs, m_xe, m_f;
  logic        m_g;

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return m_ms;
      8'h04: return m_me;
      8'h08: return {28'h0, m_xs};
      8'h0C: return {28'h0, m_xe};
      8'h10: return {28'h0, m_f};
      8'h14: return {31'h0, m_g};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_mirq();
    return m_g && ((m_ms & m_me) != 0);
  endfunction

  function automatic logic exp_xirq();
    return m_g && ((m_xs & m_xe) != 0);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic step(string tag, logic wr, logic [7:0] a, logic [31:0] d,
                      logic [31:0] ev, logic [3:0] lv);
    logic [31:0] allow, mclr;
    logic [3:0]  xclr;
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_misc = ev; intx_lvl = lv;
    @(posedge clk);
    allow = B_BR | (m_f[3] ? B_ERR : 32'h0) | (m_f[1] ? B_PM : 32'h0);
    mclr  = (wr && a == 8'h00) ? d : 32'h0;
    xclr  = (wr && a == 8'h08) ? d[3:0] : 4'h0;
    m_ms  = ((ev & allow) | (m_ms & ~mclr)) & B_IMPL;
    m_xs  = (lv & {4{m_f[2]}}) | (m_xs & ~xclr);
    if (wr) begin
      case (a)
        8'h04: m_me = d & B_IMPL;
        8'h0C: m_xe = d[3:0];
        8'h10: m_f  = d[3:0] & 4'b1110;
        8'h14: m_g  = d[0];
        default: ;
      endcase
    end
    @(negedge clk);
    check({tag, " rdata"}, reg_rdata, exp_rd(a));
    check({tag, " misc_irq"}, {31'h0, misc_irq}, {31'h0, exp_mirq()});
    check({tag, " intx_irq"}, {31'h0, intx_irq}, {31'h0, exp_xirq()});
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [3:0] lv);
    step(tag, 1'b0, a, 32'h0, 32'h0, lv);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_ms = 0; m_me = 0; m_xs = 0; m_xe = 0; m_f = 0; m_g = 0;
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; evt_misc = 0; intx_lvl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 6; k++) rd("R1 reset", 8'(k * 4), 4'h0);

    // R6 filter, R7 enables, R8 global
    step("R6 filter write", 1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 4'h0);
    step("R7 misc enable", 1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0, 4'h0);
    step("R8 global on", 1'b1, 8'h14, 32'h1, 32'h0, 4'h0);

    // R2 capture, R9 output
    step("R2 event capture", 1'b0, 8'h00, 32'h0, 32'h0001_0000, 4'h0);
    // R4 event and clear in same cycle
    step("R4 set wins", 1'b1, 8'h00, 32'h0001_0000, 32'h0001_0000, 4'h0);
    // R3 plain clear
    step("R3 w1c", 1'b1, 8'h00, 32'h0001_0000, 32'h0, 4'h0);
    step("R3 write zero", 1'b1, 8'h00, 32'h0, 32'h0000_0002, 4'h0);
    step("R3 write zero keeps", 1'b1, 8'h00, 32'h0, 32'h0, 4'h0);
    // R2 sparse layout / R10 holes
    step("R2 all events", 1'b0, 8'h00, 32'h0, 32'hFFFF_FFFF, 4'h0);
    step("R10 write holes", 1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0, 4'h0);
    // R6 filtered classes
    step("R6 filter off", 1'b1, 8'h10, 32'h0, 32'h0, 4'h0);
    step("R6 gated events", 1'b0, 8'h00, 32'h0, 32'hFFFF_FFFF, 4'h0);
    rd("R6 gated read", 8'h00, 4'h0);
    step("R6 clear", 1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0, 4'h0);

    // R5 legacy levels
    step("R5 int class on", 1'b1, 8'h10, 32'h4, 32'h0, 4'h5);
    rd("R5 level set", 8'h08, 4'h5);
    step("R5 clear while held", 1'b1, 8'h08, 32'hF, 32'h0, 4'h5);
    rd("R5 held read", 8'h08, 4'h5);
    step("R7 intx enable", 1'b1, 8'h0C, 32'hF, 32'h0, 4'h5);
    rd("R5 level dropped", 8'h08, 4'h0);
    step("R5 clear after drop", 1'b1, 8'h08, 32'h1, 32'h0, 4'h0);
    rd("R5 partial clear", 8'h08, 4'h0);

    // R8 global gate with pending status
    step("R8 pend misc", 1'b0, 8'h00, 32'h0, 32'h0000_0010, 4'h0);
    step("R8 global off", 1'b1, 8'h14, 32'h0, 32'h0, 4'h0);
    step("R8 global back", 1'b1, 8'h14, 32'h1, 32'h0, 4'h0);

    // R10 unmapped
    step("R10 unmapped write", 1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0, 4'h0);
    for (int k = 0; k < 6; k++) rd("R10 map intact", 8'(k * 4), 4'h0);

    // random traffic, R9 and register readback
    begin
      logic [3:0] lv;
      lv = 4'h0;
      for (int n = 0; n < 3000; n++) begin
        logic [7:0]  a;
        logic [31:0] d, ev;
        logic        w;
        a  = 8'(($urandom % 7) * 4);
        w  = ($urandom % 3) == 0;
        d  = $urandom;
        if (a == 8'h14) d = {31'h0, d[0] | d[1]};
        ev = $urandom & $urandom & $urandom;
        if (($urandom % 8) == 0) lv = 4'($urandom);
        step("R9 random", w, a, d, ev, lv);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule